// File: doc/BRIEF.md
# Domain Switch Context Swap Sequencer

This block carries out the memory half of a protected domain crossing. Once the permission checks are done elsewhere, it is given a sealed capability, a mode and a few register indices. It then walks a fixed program of steps. Each step either swaps one piece of architectural capability state with a 16-byte slot of a save area, or writes a computed value into a register. The save area starts at the base address of the sealed capability. The modes are a synchronous call, a synchronous return, exception entry, interrupt entry, exception return and interrupt return. The four asynchronous modes also exchange every general register from x1 to x31.

Each swap reads the slot first. It then writes the old register value back to the same slot. The register takes the read data only in the cycle the write is accepted, so a stalled memory never leaves a half-finished exchange in the register file. At the end of the program the sequencer builds the capability the crossing hands over: either a sealed-return capability that records how the crossing happened, or a capability resealed for the next call. Architectural state is reached through a single-read, single-write state port. The memory is a 128-bit port with a valid/ready request and a separate read-response valid.

Top module: `dsw_ctx_swap`

## Requirements
- R1: After reset, and at any time reset is applied, busy, done, the memory request valid and the state write enable are all low. A memory request is only raised while busy is high.
- R2: A swap issues a read of the slot, then a write of the register's current value to the same address. The register receives the read data in the cycle that write is accepted. A store step issues only the write.
- R3: While mem_ready_i is low, a pending request holds its valid, address and write flag unchanged, and the results of a crossing do not depend on how long the stalls last.
- R4: Mode 0 (call) writes null into the source register. It then swaps the pc with base+0, the exception-handler capability with base+16 and x2 with base+32. Finally it writes into x1 the sealed capability with type 5, cursor = base, reg = destination index and async = 0. The capability layout is: bits 31:0 cursor, 63:32 base, 95:64 end, 98:96 perms, 101:99 type, 103:102 async, 108:104 reg, 109 valid.
- R5: Mode 1 (synchronous return) writes null into the source register, performs the same three swaps as a call, and then writes the capability with type 4 and async 0 into the register named by its reg field. If that register is the source register, it ends up holding the capability.
- R6: Modes 2 (exception entry) and 3 (interrupt entry) swap the pc with base+0 and each x[i], for i from 1 to 31, with base+(i+1)*16. Interrupt entry also swaps the exception-handler capability with base+16. Afterwards x1 gets the capability with type 5, cursor = base, reg = 0 and async = 1 (exception) or 2 (interrupt). The handler register of that kind is then nulled, and x10 gets the zero-extended cause code.
- R7: Mode 4 (exception return) swaps the pc with base+0 and writes the exception-handler capability to base+16 without reading it. It then writes the capability resealed (type 4, async 0) into the exception-handler register, nulls the source register, and swaps x1 to x31 as in R6.
- R8: Mode 5 (interrupt return) swaps the pc with base+0 and the exception-handler capability with base+16. It then writes the resealed capability into the interrupt-handler register, nulls the source register, and swaps x1 to x31 as in R6.
- R9: No write is ever issued to state index 0, so x0 stays unchanged even when it is named as the source register.
- R10: busy rises on the edge that accepts start and stays high through the single cycle in which done is high. A start raised while busy is ignored.
- R11: State indices 0 to 31 are x0 to x31, 32 is the pc, 33 the exception-handler capability and 34 the interrupt-handler capability. Mode codes 6 and 7 raise done in the cycle after acceptance without any memory or state access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken when idle |
| mode_i | input | 3 | Crossing mode code |
| cap_i | input | 128 | Sealed capability whose base locates the save area |
| src_i | input | 5 | Source register index to be nulled |
| dst_i | input | 5 | Destination index recorded by a call |
| cause_i | input | 8 | Cause code written to x10 on entry |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_valid_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address of the slot |
| mem_wdata_o | output | 128 | Write data |
| mem_ready_i | input | 1 | Request accepted |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 128 | Read data |
| st_ridx_o | output | 6 | State read index |
| st_rdata_i | input | 128 | State read data, combinational from index |
| st_we_o | output | 1 | State write enable |
| st_widx_o | output | 6 | State write index |
| st_wdata_o | output | 128 | State write data |

## Verification
Every state and save-area result is in place by the clock edge before the cycle in which done is high. The bench therefore waits for done at the falling edge and compares the full register set and the save-area window there. The time from start to done depends on the ready pattern, so no check relies on a fixed cycle count except two: done must drop one cycle after it rises, and for the two unused mode codes done must appear one edge after acceptance. Stalls are applied every other cycle or two cycles in three, and the same expected values must hold under each pattern.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  localparam int CAP_W      = 128;
  localparam int ADDR_W     = 32;
  localparam int SLOT_BYTES = CAP_W / 8;
  localparam int SLOT_SH    = $clog2(SLOT_BYTES);
  localparam int IDX_W      = 6;
  localparam int STEP_W     = 6;
  localparam int GPR_N      = 32;
  localparam int CAUSE_W    = 8;

  localparam logic [IDX_W-1:0] IDX_RA = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_SP = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_A0 = IDX_W'(10);
  localparam logic [IDX_W-1:0] IDX_PC = IDX_W'(GPR_N);
  localparam logic [IDX_W-1:0] IDX_EH = IDX_W'(GPR_N + 1);
  localparam logic [IDX_W-1:0] IDX_IH = IDX_W'(GPR_N + 2);

  localparam logic [2:0] KIND_SEALED = 3'd4;
  localparam logic [2:0] KIND_SRET   = 3'd5;
  localparam logic [1:0] ASY_SYNC    = 2'd0;
  localparam logic [1:0] ASY_EXC     = 2'd1;
  localparam logic [1:0] ASY_INT     = 2'd2;

  typedef struct packed {
    logic [17:0]       rsvd;
    logic              valid;
    logic [4:0]        ridx;
    logic [1:0]        asy;
    logic [2:0]        kind;
    logic [2:0]        perms;
    logic [ADDR_W-1:0] top;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] cursor;
  } cap_t;

  typedef enum logic [2:0] {
    MD_CALL    = 3'd0,
    MD_RET     = 3'd1,
    MD_EXC_IN  = 3'd2,
    MD_INT_IN  = 3'd3,
    MD_EXC_OUT = 3'd4,
    MD_INT_OUT = 3'd5
  } mode_e;

  typedef enum logic [1:0] {OP_END, OP_SWAP, OP_STORE, OP_SET} op_e;
  typedef enum logic [1:0] {V_NULL, V_RETCAP, V_SEALED, V_CAUSE} vsel_e;

  typedef struct packed {
    op_e              op;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] slot;
    vsel_e            vsel;
  } step_t;

  function automatic step_t mk_step(op_e op, logic [IDX_W-1:0] idx,
                                    logic [IDX_W-1:0] slot, vsel_e v);
    step_t s;
    s.op   = op;
    s.idx  = idx;
    s.slot = slot;
    s.vsel = v;
    return s;
  endfunction
endpackage

// File: rtl/dsw_step_rom.sv
module dsw_step_rom
  import dsw_pkg::*;
(
  input  logic [2:0]        mode_i,
  input  logic [STEP_W-1:0] n_i,
  input  logic [4:0]        src_i,
  input  logic [4:0]        ridx_i,
  output step_t             step_o
);
  typedef logic [STEP_W:0] stepx_t;

  logic   is_int;
  stepx_t k_ent;
  stepx_t k_ret;
  step_t  end_s;

  assign is_int = (mode_i == MD_INT_IN) || (mode_i == MD_INT_OUT);
  assign k_ent  = {1'b0, n_i} - (is_int ? stepx_t'(2) : stepx_t'(1));
  assign k_ret  = {1'b0, n_i} - stepx_t'(4);
  assign end_s  = mk_step(OP_END, '0, '0, V_NULL);

  // register x[k+1] always lives in slot k+2
  function automatic step_t reg_swap(stepx_t k);
    return mk_step(OP_SWAP, IDX_W'(k + stepx_t'(1)), IDX_W'(k + stepx_t'(2)), V_NULL);
  endfunction

  always_comb begin
    step_o = end_s;
    case (mode_i)
      MD_CALL, MD_RET: begin
        case (n_i)
          STEP_W'(0): step_o = mk_step(OP_SET, {1'b0, src_i}, '0, V_NULL);
          STEP_W'(1): step_o = mk_step(OP_SWAP, IDX_PC, IDX_W'(0), V_NULL);
          STEP_W'(2): step_o = mk_step(OP_SWAP, IDX_EH, IDX_W'(1), V_NULL);
          STEP_W'(3): step_o = mk_step(OP_SWAP, IDX_SP, IDX_W'(2), V_NULL);
          STEP_W'(4): step_o = (mode_i == MD_CALL) ?
                               mk_step(OP_SET, IDX_RA, '0, V_RETCAP) :
                               mk_step(OP_SET, {1'b0, ridx_i}, '0, V_SEALED);
          default:    step_o = end_s;
        endcase
      end
      MD_EXC_IN, MD_INT_IN: begin
        if (n_i == STEP_W'(0))
          step_o = mk_step(OP_SWAP, IDX_PC, IDX_W'(0), V_NULL);
        else if (is_int && n_i == STEP_W'(1))
          step_o = mk_step(OP_SWAP, IDX_EH, IDX_W'(1), V_NULL);
        else if (k_ent < stepx_t'(GPR_N - 1))
          step_o = reg_swap(k_ent);
        else begin
          case (k_ent)
            stepx_t'(GPR_N - 1): step_o = mk_step(OP_SET, IDX_RA, '0, V_RETCAP);
            stepx_t'(GPR_N):     step_o = mk_step(OP_SET, is_int ? IDX_IH : IDX_EH, '0, V_NULL);
            stepx_t'(GPR_N + 1): step_o = mk_step(OP_SET, IDX_A0, '0, V_CAUSE);
            default:             step_o = end_s;
          endcase
        end
      end
      MD_EXC_OUT, MD_INT_OUT: begin
        case (n_i)
          STEP_W'(0): step_o = mk_step(OP_SWAP, IDX_PC, IDX_W'(0), V_NULL);
          STEP_W'(1): step_o = mk_step(is_int ? OP_SWAP : OP_STORE, IDX_EH, IDX_W'(1), V_NULL);
          STEP_W'(2): step_o = mk_step(OP_SET, is_int ? IDX_IH : IDX_EH, '0, V_SEALED);
          STEP_W'(3): step_o = mk_step(OP_SET, {1'b0, src_i}, '0, V_NULL);
          default:    step_o = (k_ret < stepx_t'(GPR_N - 1)) ? reg_swap(k_ret) : end_s;
        endcase
      end
      default: step_o = end_s;
    endcase
  end
endmodule

// File: rtl/dsw_cap_forge.sv
module dsw_cap_forge
  import dsw_pkg::*;
(
  input  logic [2:0]         mode_i,
  input  cap_t               cap_i,
  input  logic [4:0]         dst_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output cap_t               ret_o,
  output cap_t               seal_o,
  output logic [CAP_W-1:0]   cause_o
);
  always_comb begin
    ret_o        = cap_i;
    ret_o.kind   = KIND_SRET;
    ret_o.cursor = cap_i.base;
    case (mode_i)
      MD_CALL: begin
        ret_o.ridx = dst_i;
        ret_o.asy  = ASY_SYNC;
      end
      MD_EXC_IN: begin
        ret_o.ridx = '0;
        ret_o.asy  = ASY_EXC;
      end
      default: begin
        ret_o.ridx = '0;
        ret_o.asy  = ASY_INT;
      end
    endcase
    seal_o      = cap_i;
    seal_o.kind = KIND_SEALED;
    seal_o.asy  = ASY_SYNC;
  end

  assign cause_o = CAP_W'(cause_i);
endmodule

// File: rtl/dsw_slot_engine.sv
module dsw_slot_engine
  import dsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              store_only_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CAP_W-1:0]  old_i,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [CAP_W-1:0]  mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic              mem_rsp_valid_i,
  input  logic [CAP_W-1:0]  mem_rdata_i,
  output logic              done_o,
  output logic              commit_o,
  output logic [CAP_W-1:0]  rbuf_o
);
  typedef enum logic [1:0] {E_IDLE, E_RD, E_WAIT, E_WR} eng_e;

  eng_e             st_q, st_d;
  logic             cap_en;
  logic [CAP_W-1:0] rbuf_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      E_IDLE: if (go_i) st_d = store_only_i ? E_WR : E_RD;
      E_RD:   if (mem_ready_i) st_d = E_WAIT;
      E_WAIT: if (mem_rsp_valid_i) st_d = E_WR;
      E_WR:   if (mem_ready_i) st_d = E_IDLE;
      default: st_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= E_IDLE;
    else        st_q <= st_d;
  end

  assign cap_en = (st_q == E_WAIT) && mem_rsp_valid_i;

  always_ff @(posedge clk) begin
    if (cap_en) rbuf_q <= mem_rdata_i;
  end

  assign mem_valid_o = (st_q == E_RD) || (st_q == E_WR);
  assign mem_we_o    = (st_q == E_WR);
  assign mem_addr_o  = addr_i;
  assign mem_wdata_o = old_i;
  assign done_o      = (st_q == E_WR) && mem_ready_i;
  assign commit_o    = done_o && !store_only_i;
  assign rbuf_o      = rbuf_q;
endmodule

// File: rtl/dsw_ctx_swap.sv
module dsw_ctx_swap
  import dsw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [2:0]         mode_i,
  input  logic [CAP_W-1:0]   cap_i,
  input  logic [4:0]         src_i,
  input  logic [4:0]         dst_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               mem_valid_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [CAP_W-1:0]   mem_wdata_o,
  input  logic               mem_ready_i,
  input  logic               mem_rsp_valid_i,
  input  logic [CAP_W-1:0]   mem_rdata_i,
  output logic [IDX_W-1:0]   st_ridx_o,
  input  logic [CAP_W-1:0]   st_rdata_i,
  output logic               st_we_o,
  output logic [IDX_W-1:0]   st_widx_o,
  output logic [CAP_W-1:0]   st_wdata_o
);
  logic               run_q, run_d;
  logic [STEP_W-1:0]  n_q, n_d;
  logic               load;
  logic [2:0]         mode_q;
  cap_t               cap_q;
  logic [4:0]         src_q;
  logic [4:0]         dst_q;
  logic [CAUSE_W-1:0] cause_q;

  step_t              step;
  cap_t               ret_cap, seal_cap;
  logic [CAP_W-1:0]   cause_word;
  logic [CAP_W-1:0]   set_val;
  logic               eng_go, eng_done, eng_commit;
  logic [CAP_W-1:0]   eng_rbuf;
  logic [ADDR_W-1:0]  slot_addr;
  logic               adv, wr_any;

  dsw_step_rom u_rom (
    .mode_i (mode_q),
    .n_i    (n_q),
    .src_i  (src_q),
    .ridx_i (cap_q.ridx),
    .step_o (step)
  );

  dsw_cap_forge u_forge (
    .mode_i  (mode_q),
    .cap_i   (cap_q),
    .dst_i   (dst_q),
    .cause_i (cause_q),
    .ret_o   (ret_cap),
    .seal_o  (seal_cap),
    .cause_o (cause_word)
  );

  assign slot_addr = cap_q.base + (ADDR_W'(step.slot) << SLOT_SH);
  assign eng_go    = run_q && (step.op == OP_SWAP || step.op == OP_STORE);

  dsw_slot_engine u_eng (
    .clk             (clk),
    .rst_n           (rst_n),
    .go_i            (eng_go),
    .store_only_i    (step.op == OP_STORE),
    .addr_i          (slot_addr),
    .old_i           (st_rdata_i),
    .mem_valid_o     (mem_valid_o),
    .mem_we_o        (mem_we_o),
    .mem_addr_o      (mem_addr_o),
    .mem_wdata_o     (mem_wdata_o),
    .mem_ready_i     (mem_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rdata_i     (mem_rdata_i),
    .done_o          (eng_done),
    .commit_o        (eng_commit),
    .rbuf_o          (eng_rbuf)
  );

  assign adv = (step.op == OP_SET) || eng_done;

  always_comb begin
    run_d = run_q;
    n_d   = n_q;
    load  = 1'b0;
    if (!run_q) begin
      if (start_i) begin
        run_d = 1'b1;
        n_d   = '0;
        load  = 1'b1;
      end
    end else if (step.op == OP_END) begin
      run_d = 1'b0;
    end else if (adv) begin
      n_d = n_q + STEP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      n_q   <= '0;
    end else begin
      run_q <= run_d;
      n_q   <= n_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      mode_q  <= mode_i;
      cap_q   <= cap_i;
      src_q   <= src_i;
      dst_q   <= dst_i;
      cause_q <= cause_i;
    end
  end

  always_comb begin
    case (step.vsel)
      V_RETCAP: set_val = ret_cap;
      V_SEALED: set_val = seal_cap;
      V_CAUSE:  set_val = cause_word;
      default:  set_val = '0;
    endcase
  end

  assign wr_any     = run_q && ((step.op == OP_SET) || eng_commit);
  assign st_we_o    = wr_any && (step.idx != '0);
  assign st_widx_o  = step.idx;
  assign st_wdata_o = eng_commit ? eng_rbuf : set_val;
  assign st_ridx_o  = step.idx;
  assign busy_o     = run_q;
  assign done_o     = run_q && (step.op == OP_END);
endmodule

// File: rtl/dsw_seq_chk.sv
module dsw_seq_chk
  import dsw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              mem_valid,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              st_we,
  input logic [IDX_W-1:0]  st_widx
);
  p_mem_in_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy);

  p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));

  p_commit_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_we && mem_valid && mem_we |-> mem_ready);

  p_no_x0_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> st_widx != '0);

  p_busy_until_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);

  p_done_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_restart_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !done |=> busy);
endmodule

bind dsw_ctx_swap dsw_seq_chk u_seq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start_i),
  .busy      (busy_o),
  .done      (done_o),
  .mem_valid (mem_valid_o),
  .mem_we    (mem_we_o),
  .mem_ready (mem_ready_i),
  .mem_addr  (mem_addr_o),
  .st_we     (st_we_o),
  .st_widx   (st_widx_o)
);

// File: tb/dsw_ctx_swap_tb_top.sv
module dsw_ctx_swap_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NST  = 35;
  localparam int NMEM = 256;
  localparam int NV   = 9;

  // {mode4, base12, ridx8, src8, dst8, cause8, ctl8(stall[1:0], restart[4]), n_rd8, n_wr8}
  localparam logic [71:0] TBL [NV] = '{
    {4'd0, 12'h100, 8'd0,  8'd5, 8'd7,  8'd0, 8'h00, 8'd3,  8'd3},
    {4'd0, 12'h200, 8'd0,  8'd2, 8'd1,  8'd0, 8'h11, 8'd3,  8'd3},
    {4'd1, 12'h100, 8'd9,  8'd4, 8'd0,  8'd0, 8'h00, 8'd3,  8'd3},
    {4'd1, 12'h300, 8'd6,  8'd6, 8'd0,  8'd0, 8'h02, 8'd3,  8'd3},
    {4'd2, 12'h400, 8'd0,  8'd0, 8'd0,  8'd5, 8'h00, 8'd32, 8'd32},
    {4'd3, 12'h500, 8'd0,  8'd0, 8'd0,  8'd7, 8'h01, 8'd33, 8'd33},
    {4'd4, 12'h600, 8'd0,  8'd3, 8'd0,  8'd0, 8'h12, 8'd32, 8'd33},
    {4'd5, 12'h700, 8'd0,  8'd0, 8'd0,  8'd0, 8'h00, 8'd33, 8'd33},
    {4'd0, 12'h900, 8'd0,  8'd0, 8'd3,  8'd0, 8'h01, 8'd3,  8'd3}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [2:0]   mode_i;
  logic [127:0] cap_i;
  logic [4:0]   src_i, dst_i;
  logic [7:0]   cause_i;
  logic         busy_o, done_o;
  logic         mem_valid_o, mem_we_o;
  logic [31:0]  mem_addr_o;
  logic [127:0] mem_wdata_o;
  logic         mem_ready_i;
  logic         mem_rsp_valid_i;
  logic [127:0] mem_rdata_i;
  logic [5:0]   st_ridx_o;
  logic [127:0] st_rdata_i;
  logic         st_we_o;
  logic [5:0]   st_widx_o;
  logic [127:0] st_wdata_o;

  int checks = 0;
  int errors = 0;

  // environment model
  logic [127:0] mem [NMEM];
  logic [127:0] st  [NST];
  logic [127:0] exp_mem [NMEM];
  logic [127:0] exp_st  [NST];
  logic         load_req = 1'b0;
  logic [31:0]  load_seed = '0;
  int           rd_cnt, wr_cnt, ord_err, x0_wr;
  logic         last_rd;
  logic [31:0]  last_rd_addr;
  logic [1:0]   stall_mode = 2'd0;
  int           cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsw_ctx_swap dut_i (.*);

  function automatic logic [127:0] pat_mem(int k, logic [31:0] s);
    return {s, 32'(k), ~s, 32'(k) ^ (s << 3)};
  endfunction
  function automatic logic [127:0] pat_st(int j, logic [31:0] s);
    return (j == 0) ? 128'd0 : {32'hBEEF_0000 | s, 32'(j), s ^ 32'h1234_5678, 32'(j * 7)};
  endfunction

  assign st_rdata_i = st[st_ridx_o];

  always @(posedge clk) begin
    mem_rsp_valid_i <= 1'b0;
    if (load_req) begin
      for (int k = 0; k < NMEM; k++) mem[k] <= pat_mem(k, load_seed);
      for (int j = 0; j < NST; j++) st[j] <= pat_st(j, load_seed);
      rd_cnt <= 0; wr_cnt <= 0; ord_err <= 0; x0_wr <= 0; last_rd <= 1'b0;
    end else begin
      if (mem_valid_o && mem_ready_i) begin
        if (mem_we_o) begin
          mem[mem_addr_o[11:4]] <= mem_wdata_o;
          wr_cnt <= wr_cnt + 1;
          if (last_rd && mem_addr_o != last_rd_addr) ord_err <= ord_err + 1;
          last_rd <= 1'b0;
        end else begin
          mem_rdata_i     <= mem[mem_addr_o[11:4]];
          mem_rsp_valid_i <= 1'b1;
          rd_cnt          <= rd_cnt + 1;
          last_rd         <= 1'b1;
          last_rd_addr    <= mem_addr_o;
        end
      end
      if (st_we_o) begin
        st[st_widx_o] <= st_wdata_o;
        if (st_widx_o == 6'd0) x0_wr <= x0_wr + 1;
      end
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    case (stall_mode)
      2'd1:    mem_ready_i <= cyc[0];
      2'd2:    mem_ready_i <= (cyc % 3 == 0);
      default: mem_ready_i <= 1'b1;
    endcase
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act %h exp %h", tag, what, act, expv);
    end
  endtask

  function automatic logic [127:0] mk_cap(logic [31:0] b, logic [4:0] r);
    logic [127:0] c = '0;
    c[31:0] = b + 32'd8; c[63:32] = b; c[95:64] = b + 32'h1000;
    c[98:96] = 3'd7; c[101:99] = 3'd4; c[103:102] = 2'd0;
    c[108:104] = r; c[109] = 1'b1;
    return c;
  endfunction

  // expected-result model built from the requirements
  task automatic m_set(int idx, logic [127:0] v);
    if (idx != 0) exp_st[idx] = v;
  endtask
  task automatic m_swap(int idx, int slot0);
    logic [127:0] t = exp_mem[slot0];
    exp_mem[slot0] = exp_st[idx];
    m_set(idx, t);
  endtask
  task automatic model(int md, logic [127:0] c, int src, int dst, int cause);
    int s0 = c[63:36];
    logic [127:0] rc = c;
    logic [127:0] sc = c;
    rc[31:0] = c[63:32]; rc[101:99] = 3'd5; rc[108:104] = 5'd0; rc[103:102] = 2'd0;
    sc[101:99] = 3'd4; sc[103:102] = 2'd0;
    case (md)
      0, 1: begin
        m_set(src, '0);
        m_swap(32, s0); m_swap(33, s0 + 1); m_swap(2, s0 + 2);
        if (md == 0) begin rc[108:104] = dst[4:0]; m_set(1, rc); end
        else m_set(c[108:104], sc);
      end
      2, 3: begin
        m_swap(32, s0);
        if (md == 3) m_swap(33, s0 + 1);
        for (int i = 1; i < 32; i++) m_swap(i, s0 + i + 1);
        rc[103:102] = (md == 2) ? 2'd1 : 2'd2;
        m_set(1, rc);
        m_set((md == 2) ? 33 : 34, '0);
        m_set(10, 128'(cause));
      end
      4, 5: begin
        m_swap(32, s0);
        if (md == 4) begin exp_mem[s0 + 1] = exp_st[33]; m_set(33, sc); end
        else begin m_swap(33, s0 + 1); m_set(34, sc); end
        m_set(src, '0);
        for (int i = 1; i < 32; i++) m_swap(i, s0 + i + 1);
      end
      default: ;
    endcase
  endtask

  function automatic string tag_of(int md);
    case (md)
      0: return "R4";
      1: return "R5";
      2, 3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic load_env(logic [31:0] seed);
    @(negedge clk);
    load_seed = seed; load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    for (int k = 0; k < NMEM; k++) exp_mem[k] = pat_mem(k, seed);
    for (int j = 0; j < NST; j++) exp_st[j] = pat_st(j, seed);
  endtask

  // drives one crossing, returns cycles to done (-1 on timeout)
  task automatic run_op(int md, logic [127:0] c, int src, int dst, int cause,
                        bit restart, output int lat, output bit busy_ok);
    lat = -1; busy_ok = 1'b1;
    @(negedge clk);
    start_i = 1'b1; mode_i = md[2:0]; cap_i = c;
    src_i = src[4:0]; dst_i = dst[4:0]; cause_i = cause[7:0];
    @(negedge clk);
    start_i = 1'b0;
    for (int t = 1; t < 2000; t++) begin
      if (done_o) begin lat = t; break; end
      if (!busy_o) busy_ok = 1'b0;
      if (restart && t == 5) begin
        start_i = 1'b1; mode_i = 3'd3; cap_i = mk_cap(32'h0E00, 5'd1);
        src_i = 5'd9; cause_i = 8'hEE;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
  endtask

  initial begin
    int  lat;
    bit  bok;
    rst_n = 1'b0; start_i = 1'b0; mode_i = '0; cap_i = '0;
    src_i = '0; dst_i = '0; cause_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o && !mem_valid_o && !st_we_o, "R1", "reset outputs",
        {busy_o, done_o, mem_valid_o, st_we_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (TBL[v]) begin
      logic [71:0] e = TBL[v];
      int md = e[71:68];
      logic [31:0] b = {20'd0, e[67:56]};
      logic [127:0] c = mk_cap(b, e[52:48]);
      string tg = tag_of(md);
      int s0 = b[31:4];
      load_env(32'(v + 1));
      model(md, c, e[47:40], e[39:32], e[31:24]);
      stall_mode = e[17:16];   // R3 when non-zero
      run_op(md, c, e[47:40], e[39:32], e[31:24], e[20], lat, bok);
      chk(lat > 0, "R10", $sformatf("op %0d done seen", v), lat, 1);
      chk(bok, "R10", $sformatf("op %0d busy held", v), bok, 1);
      for (int j = 0; j < NST; j++)
        chk(st[j] === exp_st[j], tg, $sformatf("op %0d state %0d", v, j), st[j], exp_st[j]);
      for (int k = s0; k < s0 + 34; k++)
        chk(mem[k] === exp_mem[k], tg, $sformatf("op %0d slot %0d", v, k - s0), mem[k], exp_mem[k]);
      chk(rd_cnt == e[15:8], "R2", $sformatf("op %0d reads", v), rd_cnt, e[15:8]);
      chk(wr_cnt == e[7:0], "R2", $sformatf("op %0d writes", v), wr_cnt, e[7:0]);
      chk(ord_err == 0, "R2", $sformatf("op %0d write addr follows read", v), ord_err, 0);
      chk(x0_wr == 0, "R9", $sformatf("op %0d x0 writes", v), x0_wr, 0);
      @(negedge clk);
      chk(!done_o && !busy_o, "R10", $sformatf("op %0d done one cycle", v), {done_o, busy_o}, 0);
      stall_mode = 2'd0;
    end

    // R11: unused mode codes finish one edge after acceptance, no access
    for (int m = 6; m < 8; m++) begin
      load_env(32'h77 + m);
      run_op(m, mk_cap(32'h100, 5'd3), 4, 4, 1, 1'b0, lat, bok);
      chk(lat == 1, "R11", $sformatf("mode %0d latency", m), lat, 1);
      chk(rd_cnt == 0 && wr_cnt == 0, "R11", $sformatf("mode %0d mem access", m), rd_cnt + wr_cnt, 0);
      chk(st[4] === pat_st(4, 32'h77 + m), "R11", $sformatf("mode %0d state", m), st[4], pat_st(4, 32'h77 + m));
    end

    // R1: reset in the middle of a crossing
    load_env(32'h99);
    @(negedge clk);
    start_i = 1'b1; mode_i = 3'd3; cap_i = mk_cap(32'h400, 5'd0);
    @(negedge clk);
    start_i = 1'b0;
    repeat (8) @(negedge clk);
    chk(busy_o, "R1", "busy before reset", busy_o, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && !mem_valid_o && !st_we_o, "R1", "mid-op reset outputs",
        {busy_o, done_o, mem_valid_o, st_we_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired act 0 exp 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule